// File: doc/BRIEF.md
# Page-Class Key Access Checker

This unit sits beside the permission stage of a hashed-page-table MMU. Each page belongs to one of 32 classes, named by a 5-bit key held in its table entry. A 64-bit class mask register holds two deny bits for each class, one for loads and one for stores. For every translated access the unit combines the base page permissions with the permissions left after the class mask is applied. It then reports the effective read/write/execute set and whether the access faults. A data fault records a cause word and the effective address. An instruction-fetch fault raises its own pulse with a fixed code.

The class mask register can be written from user mode as well as privileged mode. A user-mode write only reaches the bits enabled by a second register, the user-write mask, which only privileged writes may change. The class stage never limits instruction fetch, and it can be bypassed entirely with a feature-enable input.

Permission and fault outputs are combinational from the access inputs. The fault pulses, the instruction code, the data cause word and the captured address are registered on the clock edge that samples the access.

Top module: `pkc_checker`

## Requirements
- R1: After reset the class mask, the user-write mask, the data cause word and the captured address read zero, and both fault pulses are low.
- R2: Key k selects the bit pair at positions 2*(31-k)+1 and 2*(31-k) of the class mask, so key 0 uses bits 63:62 and key 31 uses bits 1:0.
- R3: In a selected pair, the upper bit set denies stores and the lower bit set denies loads for that class.
- R4: The class mask never removes execute permission; a fetch (acc_type 2) faults only when bit 2 of the base permissions is clear.
- R5: With feat_en low, the class stage grants everything and perm_o equals the base permissions.
- R6: perm_o, ordered {exec, write, read}, is the AND of base and class permissions. fault_o is high when acc_valid is set and the requested bit is absent (acc_type 0 = load needs read, 1 = store needs write, 2 = fetch needs exec).
- R7: On a data fault, data_fault_o pulses for one cycle after the sampling edge. dstat_o becomes the OR of 0x08000000 (base denies), 0x02000000 (access is a store) and 0x00200000 (class mask denies).
- R8: On a fetch fault, inst_fault_o pulses with inst_code_o = 0x08000000, and dstat_o and daddr_o keep their values.
- R9: daddr_o captures acc_ea on a data fault. An access that does not fault leaves dstat_o and daddr_o unchanged.
- R10: A privileged write with wr_sel = 0 replaces all 64 class-mask bits. A user write with wr_sel = 0 changes only the bits set in the user-write mask.
- R11: The user-write mask (wr_sel = 1) changes only on a privileged write; a user write to it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Enables class-key protection |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = class mask, 1 = user-write mask |
| wr_priv | input | 1 | Write issued in privileged mode |
| wr_data | input | 64 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| acc_key | input | 5 | Page class key |
| acc_base_perm | input | 3 | Base {exec, write, read} |
| acc_ea | input | 64 | Effective address of the access |
| amr_o | output | 64 | Class mask register value |
| umask_o | output | 64 | User-write mask value |
| perm_o | output | 3 | Effective {exec, write, read} |
| fault_o | output | 1 | Access is denied |
| data_fault_o | output | 1 | Registered data-fault pulse |
| inst_fault_o | output | 1 | Registered fetch-fault pulse |
| inst_code_o | output | 32 | Fetch-fault code, valid with its pulse |
| dstat_o | output | 32 | Data-fault cause word |
| daddr_o | output | 64 | Captured faulting address |

## Verification
The bench drives keys 0 and 31 so that a reversed pair index, which would read the opposite end of the register, is caught. Stores denied by both the base protection and the class mask are checked against a cause word with three bits set, which exposes a unit that reports only one cause. A fully denying class mask is paired with fetches and with a cleared feature enable, to catch a class stage that leaks into execute or ignores the enable. A user write to the user-write mask, and a user write to the class mask under a partial user-write mask, are read back to catch unfiltered writes.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam logic [31:0] CAUSE_BASE  = 32'h0800_0000;
  localparam logic [31:0] CAUSE_STORE = 32'h0200_0000;
  localparam logic [31:0] CAUSE_KEY   = 32'h0020_0000;
  localparam logic [31:0] FETCH_CODE  = 32'h0800_0000;

  // Permission bit an access kind requires.
  function automatic logic [2:0] need_of(acc_kind_e kind);
    logic [2:0] n;
    n = 3'b000;
    case (kind)
      ACC_LOAD:  n[PERM_R] = 1'b1;
      ACC_STORE: n[PERM_W] = 1'b1;
      ACC_FETCH: n[PERM_X] = 1'b1;
      default:   n = 3'b000;
    endcase
    return n;
  endfunction

  // A deny pair {store_deny, load_deny} becomes a grant set; execute always granted.
  function automatic logic [2:0] grant_of(logic [1:0] deny_pair);
    logic [2:0] g;
    g[PERM_X] = 1'b1;
    g[PERM_W] = ~deny_pair[1];
    g[PERM_R] = ~deny_pair[0];
    return g;
  endfunction

  // Cause word from the three fault sources.
  function automatic logic [31:0] cause_of(logic base_deny, logic is_store, logic key_deny);
    logic [31:0] c;
    c = 32'h0;
    if (base_deny) c = c | CAUSE_BASE;
    if (is_store)  c = c | CAUSE_STORE;
    if (key_deny)  c = c | CAUSE_KEY;
    return c;
  endfunction

endpackage

// File: rtl/pkc_mask_regs.sv
module pkc_mask_regs #(
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_priv,
  input  logic [MASK_W-1:0] wr_data,
  output logic [MASK_W-1:0] amr_q,
  output logic [MASK_W-1:0] umask_q
);

  logic              amr_wr_ev;
  logic              um_wr_ev;
  logic              um_user_drop;
  logic [MASK_W-1:0] amr_user_merge;
  logic [MASK_W-1:0] amr_next;

  assign amr_wr_ev      = wr_en && !wr_sel;
  assign um_wr_ev       = wr_en && wr_sel && wr_priv;
  assign um_user_drop   = wr_en && wr_sel && !wr_priv;
  assign amr_user_merge = (amr_q & ~umask_q) | (wr_data & umask_q);
  assign amr_next       = wr_priv ? wr_data : amr_user_merge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amr_q   <= '0;
      umask_q <= '0;
    end else begin
      if (amr_wr_ev) amr_q   <= amr_next;
      if (um_wr_ev)  umask_q <= wr_data;
    end
  end

  // R11
  umask_user_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    um_user_drop |=> $stable(umask_q));

  // R10
  amr_user_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amr_wr_ev && !wr_priv) |=> (((amr_q ^ $past(amr_q)) & ~$past(umask_q)) == '0));

  // R10
  amr_priv_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amr_wr_ev && wr_priv) |=> (amr_q == $past(wr_data)));

endmodule

// File: rtl/pkc_class_perm.sv
module pkc_class_perm
  import pkc_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic [2*(1<<KEY_W)-1:0] mask,
  input  logic [KEY_W-1:0]        key,
  input  logic                    feat_en,
  output logic [2:0]              cls_perm
);

  localparam int NCLASS = 1 << KEY_W;

  logic [1:0] pairs [NCLASS];
  logic [1:0] sel_pair;

  // Key 0 owns the most significant pair.
  for (genvar g = 0; g < NCLASS; g++) begin : g_pair
    assign pairs[g] = mask[2*(NCLASS-1-g) +: 2];
  end

  assign sel_pair = pairs[key];
  assign cls_perm = feat_en ? grant_of(sel_pair) : 3'b111;

endmodule

// File: rtl/pkc_fault_gen.sv
module pkc_fault_gen
  import pkc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  acc_kind_e         acc_kind,
  input  logic [2:0]        base_perm,
  input  logic [2:0]        cls_perm,
  input  logic [ADDR_W-1:0] ea,
  output logic [2:0]        eff_perm,
  output logic              fault,
  output logic              data_fault_q,
  output logic              inst_fault_q,
  output logic [31:0]       inst_code_q,
  output logic [31:0]       dstat_q,
  output logic [ADDR_W-1:0] daddr_q
);

  logic [2:0]  need;
  logic        base_deny;
  logic        key_deny;
  logic        is_fetch;
  logic        dfault_ev;
  logic        ifault_ev;
  logic [31:0] cause;

  assign need      = need_of(acc_kind);
  assign eff_perm  = base_perm & cls_perm;
  assign base_deny = |(need & ~base_perm);
  assign key_deny  = |(need & ~cls_perm);
  assign is_fetch  = (acc_kind == ACC_FETCH);
  assign fault     = acc_valid && |(need & ~eff_perm);
  assign dfault_ev = fault && !is_fetch;
  assign ifault_ev = fault && is_fetch;
  assign cause     = cause_of(base_deny, acc_kind == ACC_STORE, key_deny);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_fault_q <= 1'b0;
      inst_fault_q <= 1'b0;
      inst_code_q  <= '0;
      dstat_q      <= '0;
      daddr_q      <= '0;
    end else begin
      data_fault_q <= dfault_ev;
      inst_fault_q <= ifault_ev;
      inst_code_q  <= ifault_ev ? FETCH_CODE : 32'h0;
      if (dfault_ev) begin
        dstat_q <= cause;
        daddr_q <= ea;
      end
    end
  end

  // R7
  dstat_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_fault_q |-> ((dstat_q & (CAUSE_BASE | CAUSE_KEY)) != 32'h0));

  // R8
  fault_kinds_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_fault_q && inst_fault_q));

  // R8
  inst_keeps_dstat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_fault_q |-> ($stable(dstat_q) && $stable(daddr_q)));

  // R9
  daddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_fault_q |-> $stable(daddr_q));

endmodule

// File: rtl/pkc_checker.sv
module pkc_checker
  import pkc_pkg::*;
#(
  parameter int KEY_W  = 5,
  parameter int ADDR_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      feat_en,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic                      wr_priv,
  input  logic [2*(1<<KEY_W)-1:0]   wr_data,
  input  logic                      acc_valid,
  input  logic [1:0]                acc_type,
  input  logic [KEY_W-1:0]          acc_key,
  input  logic [2:0]                acc_base_perm,
  input  logic [ADDR_W-1:0]         acc_ea,
  output logic [2*(1<<KEY_W)-1:0]   amr_o,
  output logic [2*(1<<KEY_W)-1:0]   umask_o,
  output logic [2:0]                perm_o,
  output logic                      fault_o,
  output logic                      data_fault_o,
  output logic                      inst_fault_o,
  output logic [31:0]               inst_code_o,
  output logic [31:0]               dstat_o,
  output logic [ADDR_W-1:0]         daddr_o
);

  localparam int NCLASS = 1 << KEY_W;
  localparam int MASK_W = 2 * NCLASS;

  logic [2:0] cls_perm;
  acc_kind_e  acc_kind;

  assign acc_kind = acc_kind_e'(acc_type);

  pkc_mask_regs #(.MASK_W(MASK_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_priv (wr_priv),
    .wr_data (wr_data),
    .amr_q   (amr_o),
    .umask_q (umask_o)
  );

  pkc_class_perm #(.KEY_W(KEY_W)) u_class (
    .mask     (amr_o),
    .key      (acc_key),
    .feat_en  (feat_en),
    .cls_perm (cls_perm)
  );

  pkc_fault_gen #(.ADDR_W(ADDR_W)) u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_kind     (acc_kind),
    .base_perm    (acc_base_perm),
    .cls_perm     (cls_perm),
    .ea           (acc_ea),
    .eff_perm     (perm_o),
    .fault        (fault_o),
    .data_fault_q (data_fault_o),
    .inst_fault_q (inst_fault_o),
    .inst_code_q  (inst_code_o),
    .dstat_q      (dstat_o),
    .daddr_q      (daddr_o)
  );

  // R5
  feat_off_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |-> (cls_perm == 3'b111));

  // R4
  exec_from_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_o[PERM_X] == acc_base_perm[PERM_X]);

endmodule

// File: tb/pkc_checker_test.sv
`timescale 1ns/1ps
module pkc_checker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, wr_priv = 1'b0;
  logic [63:0] wr_data = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_type = 2'd0;
  logic [4:0]  acc_key = '0;
  logic [2:0]  acc_base_perm = '0;
  logic [63:0] acc_ea = '0;
  logic [63:0] amr_o, umask_o, daddr_o;
  logic [2:0]  perm_o;
  logic        fault_o, data_fault_o, inst_fault_o;
  logic [31:0] inst_code_o, dstat_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic        df;
    logic        inf;
    logic [31:0] code;
    logic [31:0] st;
    logic [63:0] ad;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  logic [63:0] amr_m = '0, um_m = '0;
  logic [31:0] st_m = '0;
  logic [63:0] ad_m = '0;

  always #2.5 clk = ~clk;

  pkc_checker uut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_priv(wr_priv), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_type(acc_type), .acc_key(acc_key),
    .acc_base_perm(acc_base_perm), .acc_ea(acc_ea),
    .amr_o(amr_o), .umask_o(umask_o), .perm_o(perm_o), .fault_o(fault_o),
    .data_fault_o(data_fault_o), .inst_fault_o(inst_fault_o),
    .inst_code_o(inst_code_o), .dstat_o(dstat_o), .daddr_o(daddr_o)
  );

  task automatic chk(string req, string what, logic [191:0] act, logic [191:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Class grant restated from the bit layout: shift the chosen pair down to bit 0.
  function automatic logic [2:0] model_cls(logic [4:0] key, logic feat);
    logic [63:0] sh;
    if (!feat) return 3'b111;
    sh = amr_m >> (62 - 2 * int'(key));
    return {1'b1, !sh[1], !sh[0]};
  endfunction

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic reg_write(logic sel, logic priv, logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_priv = priv; wr_data = d;
    if (!sel) amr_m = priv ? d : ((amr_m & ~um_m) | (d & um_m));
    else if (priv) um_m = d;
  endtask

  task automatic access(string req, logic [4:0] key, logic [2:0] base, logic [1:0] typ,
                        logic [63:0] ea, logic feat);
    logic [2:0] need, cls, eff;
    logic       flt;
    exp_t       e;
    @(negedge clk);
    wr_en = 1'b0;
    acc_valid = 1'b1; acc_key = key; acc_base_perm = base; acc_type = typ;
    acc_ea = ea; feat_en = feat;
    need = (typ == 2'd0) ? 3'b001 : (typ == 2'd1) ? 3'b010 : 3'b100;
    cls  = model_cls(key, feat);
    eff  = base & cls;
    flt  = (need & eff) == 3'b000;
    #1;
    chk(req, "perm_o", 192'(perm_o), 192'(eff));
    chk(req, "fault_o", 192'(fault_o), 192'(flt));
    e.df = flt && (typ != 2'd2);
    e.inf = flt && (typ == 2'd2);
    e.code = e.inf ? 32'h0800_0000 : 32'h0;
    if (e.df) begin
      st_m = ((need & base) == 0 ? 32'h0800_0000 : 32'h0)
           | (typ == 2'd1 ? 32'h0200_0000 : 32'h0)
           | ((need & cls) == 0 ? 32'h0020_0000 : 32'h0);
      ad_m = ea;
    end
    e.st = st_m;
    e.ad = ad_m;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  // Monitor: each sampled access yields one registered result, compared a half cycle later.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && acc_valid) begin
        exp_t  e;
        string r;
        @(negedge clk);
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, "registered {df,if,code,dstat,daddr}",
            192'({data_fault_o, inst_fault_o, inst_code_o, dstat_o, daddr_o}), 192'(e));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "amr_o", 192'(amr_o), 192'(0));
    chk("R1", "umask_o", 192'(umask_o), 192'(0));
    chk("R1", "dstat/daddr", 192'({dstat_o, daddr_o}), 192'(0));
    chk("R1", "pulses", 192'({data_fault_o, inst_fault_o}), 192'(0));

    // R10 privileged write: key 0 store-deny, key 31 load-deny
    reg_write(1'b0, 1'b1, 64'h8000_0000_0000_0001);
    idle();
    chk("R10", "amr_o priv", 192'(amr_o), 192'(amr_m));

    access("R2 R3 R7 key0 store", 5'd0, 3'b111, 2'd1, 64'hA000_0000_0000_0010, 1'b1);
    access("R3 R9 key0 load ok", 5'd0, 3'b111, 2'd0, 64'hA000_0000_0000_0020, 1'b1);
    access("R2 R3 R7 key31 load", 5'd31, 3'b111, 2'd0, 64'hB000_0000_0000_0030, 1'b1);
    access("R3 R6 key31 store ok", 5'd31, 3'b111, 2'd1, 64'hB000_0000_0000_0040, 1'b1);
    access("R6 R7 base-only load", 5'd5, 3'b110, 2'd0, 64'hC000_0000_0000_0050, 1'b1);

    reg_write(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    access("R7 both causes store", 5'd9, 3'b101, 2'd1, 64'hD000_0000_0000_0060, 1'b1);
    access("R4 fetch not limited", 5'd9, 3'b100, 2'd2, 64'hD000_0000_0000_0070, 1'b1);
    access("R8 fetch fault", 5'd9, 3'b011, 2'd2, 64'hD000_0000_0000_0080, 1'b1);
    access("R5 feature off load", 5'd3, 3'b011, 2'd0, 64'hE000_0000_0000_0090, 1'b0);
    access("R5 R7 feature off store", 5'd3, 3'b001, 2'd1, 64'hE000_0000_0000_00A0, 1'b0);
    idle();

    // R11 user write to the user-write mask is ignored
    reg_write(1'b1, 1'b0, 64'h0000_0000_0000_FFFF);
    idle();
    chk("R11", "umask_o user", 192'(umask_o), 192'(0));
    reg_write(1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF);
    idle();
    chk("R11", "umask_o priv", 192'(umask_o), 192'(64'h0000_0000_FFFF_FFFF));
    // R10 user write filtered by the user-write mask
    reg_write(1'b0, 1'b0, 64'h0);
    idle();
    chk("R10", "amr_o user", 192'(amr_o), 192'(64'hFFFF_FFFF_0000_0000));

    access("R2 R10 key31 cleared", 5'd31, 3'b111, 2'd0, 64'hF000_0000_0000_00B0, 1'b1);
    access("R2 R10 key0 still set", 5'd0, 3'b111, 2'd0, 64'hF000_0000_0000_00C0, 1'b1);
    idle();
    idle();
    chk("R7", "pulse drops", 192'({data_fault_o, inst_fault_o}), 192'(0));
    finish_run();
  end

endmodule